// File: doc/BRIEF.md
# Masked Vector Element Execution Unit

This unit runs one element-wise vector operation at a time under a per-element predicate. Operands are read from an external vector register file through a shared element index. Results go out through a write port that carries its own per-element enable. An internal predicate register holds one bit per element. Two test operations build it: one checks an element for non-zero, the other compares two elements as signed values (greater than or equal). A third operation inverts it. Two complementary masked moves can therefore merge two vectors, for example into an element-wise maximum.

Arithmetic operations (add, multiply, copy) write only the elements whose predicate bit is set and whose index lies below the active length. A mode input picks one of two schedules. In the full-sweep schedule the unit spends one cycle on every index below the length and suppresses the write where the bit is clear. In the sparse schedule a one-cycle search jumps straight to the next set bit, so the run takes as many cycles as there are active elements.

Top module: `vmask_exec`

## Requirements
- R1: After reset `busy_o`, `done_o` and `wr_en_o` are low and `mask_o` is all zero.
- R2: Operation code 3 (test non-zero) sets predicate bit i to (A[i] != 0) for every i below the length and clears every bit at or above it; it takes length+1 cycles from the start edge to `done_o`.
- R3: Operation code 4 (test compare) sets predicate bit i to (signed A[i] >= signed B[i]) below the length, clears the bits above it, and has the same timing as R2.
- R4: Operation code 5 (invert) inverts every predicate bit below the length and clears the bits at or above it, with `done_o` one cycle after the start edge; a compare, masked copy of A, invert and masked copy of B leave the element-wise signed maximum.
- R5: Operation codes 0 (add), 1 (multiply) and 2 (copy A) write the signed result, wrapped to the element width, to element i only when predicate bit i is 1 and i is below the length; no other element is written and the predicate is left unchanged.
- R6: With `dense_i` = 0 an arithmetic operation takes length+1 cycles from the start edge to `done_o`; a length above the element count is treated as the element count.
- R7: With `dense_i` = 1 an arithmetic operation takes k+1 cycles, where k is the number of set predicate bits below the length.
- R8: A length of zero, or a sparse run with no set bit in range, writes nothing and raises `done_o` one cycle after the start edge.
- R9: `start_i` is ignored while an operation is running: the run keeps its timing and results, and the predicate is unchanged.
- R10: Operation codes 6 and 7 write nothing, leave the predicate unchanged, and raise `done_o` one cycle after the start edge.
- R11: `done_o` is a single-cycle pulse, and `busy_o` is low while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (sampled only when idle) |
| op_i | input | 3 | Operation code |
| dense_i | input | 1 | 1 = sparse schedule, 0 = full sweep |
| vlen_i | input | LW | Active length in elements |
| rd_idx_o | output | IDXW | Element index presented to the register file |
| rd_a_i | input | EW | Element A at `rd_idx_o` (same cycle) |
| rd_b_i | input | EW | Element B at `rd_idx_o` (same cycle) |
| wr_en_o | output | 1 | Write enable for the element at `wr_idx_o` |
| wr_idx_o | output | IDXW | Destination element index |
| wr_data_o | output | EW | Result value |
| mask_o | output | NELEM | Predicate register |
| busy_o | output | 1 | An element is being processed this cycle |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The unit latches a command at the start edge. It then spends exactly N processing cycles, where N is the length, the active-bit count or zero. `done_o` rises after N+1 edges. The bench counts falling edges from the start edge until `done_o` is seen and compares that count with N+1 worked out from its own predicate model. Writes take effect at the edge that ends each processing cycle, so the destination vector and `mask_o` are compared only after `done_o`. Once all writes have landed, the bench checks on the next falling edge that the pulse has dropped.

// File: rtl/vmx_pkg.sv
package vmx_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_MUL  = 3'd1,
        OP_PASS = 3'd2,
        OP_TNZ  = 3'd3,
        OP_TGE  = 3'd4,
        OP_MINV = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } vop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } vst_e;

    function automatic logic op_is_arith(vop_e op);
        return (op == OP_ADD) || (op == OP_MUL) || (op == OP_PASS);
    endfunction

    function automatic logic op_is_test(vop_e op);
        return (op == OP_TNZ) || (op == OP_TGE);
    endfunction

endpackage

// File: rtl/vmx_scan.sv
// Finds the lowest set bit whose index lies in [from, lim).
module vmx_scan #(
    parameter int N  = 8,
    parameter int LW = 4
) (
    input  logic [N-1:0]  bits_i,
    input  logic [LW-1:0] from_i,
    input  logic [LW-1:0] lim_i,
    output logic          found_o,
    output logic [LW-1:0] pos_o
);
    logic [N-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_hit
            assign hit[g] = bits_i[g] && (LW'(g) >= from_i) && (LW'(g) < lim_i);
        end
    endgenerate

    always_comb begin
        found_o = 1'b0;
        pos_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                found_o = 1'b1;
                pos_o   = LW'(i);
            end
        end
    end
endmodule

// File: rtl/vmx_alu.sv
module vmx_alu
    import vmx_pkg::*;
#(
    parameter int EW = 16
) (
    input  vop_e          op_i,
    input  logic [EW-1:0] a_i,
    input  logic [EW-1:0] b_i,
    output logic [EW-1:0] res_o
);
    logic [EW-1:0] sum;
    logic [EW-1:0] prod;

    // low EW bits of a two's-complement product equal the unsigned ones
    assign sum  = a_i + b_i;
    assign prod = a_i * b_i;

    always_comb begin
        case (op_i)
            OP_ADD:  res_o = sum;
            OP_MUL:  res_o = prod;
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/vmx_test.sv
module vmx_test
    import vmx_pkg::*;
#(
    parameter int EW = 16
) (
    input  vop_e          op_i,
    input  logic [EW-1:0] a_i,
    input  logic [EW-1:0] b_i,
    output logic          bit_o
);
    always_comb begin
        if (op_i == OP_TGE) bit_o = ($signed(a_i) >= $signed(b_i));
        else                bit_o = (a_i != '0);
    end
endmodule

// File: rtl/vmask_exec.sv
module vmask_exec
    import vmx_pkg::*;
#(
    parameter  int NELEM = 8,
    parameter  int EW    = 16,
    localparam int IDXW  = (NELEM > 1) ? $clog2(NELEM) : 1,
    localparam int LW    = $clog2(NELEM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       op_i,
    input  logic             dense_i,
    input  logic [LW-1:0]    vlen_i,
    output logic [IDXW-1:0]  rd_idx_o,
    input  logic [EW-1:0]    rd_a_i,
    input  logic [EW-1:0]    rd_b_i,
    output logic             wr_en_o,
    output logic [IDXW-1:0]  wr_idx_o,
    output logic [EW-1:0]    wr_data_o,
    output logic [NELEM-1:0] mask_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [LW-1:0] LEN_MAX = LW'(NELEM);

    typedef struct packed {
        vst_e             st;
        vop_e             op;
        logic             dense;
        logic [LW-1:0]    vlen;
        logic [LW-1:0]    idx;
        logic [NELEM-1:0] mask;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [LW-1:0]   len_in;
    logic [LW-1:0]   scan_from;
    logic [LW-1:0]   scan_lim;
    logic            scan_found;
    logic [LW-1:0]   scan_pos;
    logic [EW-1:0]   alu_res;
    logic            test_bit;
    logic [IDXW-1:0] idx_lo;
    vop_e            op_in;

    assign op_in   = vop_e'(op_i);
    assign len_in  = (vlen_i > LEN_MAX) ? LEN_MAX : vlen_i;
    assign idx_lo  = ctx_q.idx[IDXW-1:0];

    // from idle the search starts at element 0, while running it resumes past the current one
    assign scan_from = (ctx_q.st == ST_IDLE) ? '0 : (ctx_q.idx + LW'(1));
    assign scan_lim  = (ctx_q.st == ST_IDLE) ? len_in : ctx_q.vlen;

    vmx_scan #(.N(NELEM), .LW(LW)) u_scan (
        .bits_i  (ctx_q.mask),
        .from_i  (scan_from),
        .lim_i   (scan_lim),
        .found_o (scan_found),
        .pos_o   (scan_pos)
    );

    vmx_alu #(.EW(EW)) u_alu (
        .op_i  (ctx_q.op),
        .a_i   (rd_a_i),
        .b_i   (rd_b_i),
        .res_o (alu_res)
    );

    vmx_test #(.EW(EW)) u_test (
        .op_i  (ctx_q.op),
        .a_i   (rd_a_i),
        .b_i   (rd_b_i),
        .bit_o (test_bit)
    );

    always_comb begin
        ctx_d = ctx_q;
        case (ctx_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctx_d.op    = op_in;
                    ctx_d.dense = dense_i;
                    ctx_d.vlen  = len_in;
                    ctx_d.idx   = '0;
                    if (op_is_test(op_in)) begin
                        ctx_d.mask = '0;
                        ctx_d.st   = (len_in == '0) ? ST_DONE : ST_RUN;
                    end else if (op_in == OP_MINV) begin
                        for (int i = 0; i < NELEM; i++)
                            ctx_d.mask[i] = (LW'(i) < len_in) && !ctx_q.mask[i];
                        ctx_d.st = ST_DONE;
                    end else if (op_is_arith(op_in)) begin
                        if (dense_i) begin
                            ctx_d.idx = scan_pos;
                            ctx_d.st  = scan_found ? ST_RUN : ST_DONE;
                        end else begin
                            ctx_d.st  = (len_in == '0) ? ST_DONE : ST_RUN;
                        end
                    end else begin
                        ctx_d.st = ST_DONE;
                    end
                end
            end
            ST_RUN: begin
                if (op_is_test(ctx_q.op))
                    ctx_d.mask[idx_lo] = test_bit;
                if (op_is_arith(ctx_q.op) && ctx_q.dense) begin
                    ctx_d.idx = scan_pos;
                    ctx_d.st  = scan_found ? ST_RUN : ST_DONE;
                end else if ((ctx_q.idx + LW'(1)) < ctx_q.vlen) begin
                    ctx_d.idx = ctx_q.idx + LW'(1);
                end else begin
                    ctx_d.st = ST_DONE;
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, op: OP_ADD, dense: 1'b0,
                       vlen: '0, idx: '0, mask: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign rd_idx_o  = idx_lo;
    assign wr_idx_o  = idx_lo;
    assign wr_data_o = alu_res;
    assign wr_en_o   = (ctx_q.st == ST_RUN) && op_is_arith(ctx_q.op) && ctx_q.mask[idx_lo];
    assign mask_o    = ctx_q.mask;
    assign busy_o    = (ctx_q.st == ST_RUN);
    assign done_o    = (ctx_q.st == ST_DONE);

    // ---------------- assertions ----------------
    assert_wr_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (busy_o && mask_o[wr_idx_o]));

    assert_idx_in_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (ctx_q.idx < ctx_q.vlen));

    assert_dense_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ctx_q.dense && op_is_arith(ctx_q.op)) |-> ctx_q.mask[idx_lo]);

    assert_scan_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_found |-> (ctx_q.mask[scan_pos[IDXW-1:0]] && (scan_pos >= scan_from)));

    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && op_is_arith(ctx_q.op)) |=> $stable(mask_o));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(ctx_q.op) && $stable(ctx_q.vlen)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
endmodule

// File: tb/vmask_exec_tb.sv
module vmask_exec_tb;
    localparam int NE  = 8;
    localparam int EW  = 16;
    localparam int IW  = 3;
    localparam int LW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    op = 3'd0;
    logic          dense = 1'b0;
    logic [LW-1:0] vlen = '0;
    logic [IW-1:0] rd_idx;
    logic [EW-1:0] rd_a, rd_b;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [EW-1:0] wr_data;
    logic [NE-1:0] mask;
    logic          busy, done;

    logic [EW-1:0] va [NE];
    logic [EW-1:0] vb [NE];
    logic [EW-1:0] vd [NE];
    logic [EW-1:0] vd_m [NE];
    logic [NE-1:0] mask_m;
    logic          clr_vd = 1'b0;

    int total = 0;
    int bad   = 0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    vmask_exec #(.NELEM(NE), .EW(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .dense_i(dense),
        .vlen_i(vlen), .rd_idx_o(rd_idx), .rd_a_i(rd_a), .rd_b_i(rd_b),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
        .mask_o(mask), .busy_o(busy), .done_o(done)
    );

    assign rd_a = va[rd_idx];
    assign rd_b = vb[rd_idx];

    always @(posedge clk) begin
        if (clr_vd) begin
            for (int i = 0; i < NE; i++) vd[i] <= EW'(16'hA000 + i);
        end else if (wr_en) begin
            vd[wr_idx] <= wr_data;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_pat(input int p);
        for (int i = 0; i < NE; i++) begin
            va[i] = (((i + p) % 3) == 0) ? '0 : EW'(p * 4099 + i * 30011 - 20000);
            vb[i] = EW'(i * 21001 + p * 977 - 50000);
        end
    endtask

    task automatic clear_vd();
        @(negedge clk); clr_vd = 1'b1;
        @(negedge clk); clr_vd = 1'b0;
        for (int i = 0; i < NE; i++) vd_m[i] = EW'(16'hA000 + i);
    endtask

    function automatic logic [EW-1:0] model_res(input int o, input logic [EW-1:0] a,
                                                input logic [EW-1:0] b);
        logic [2*EW-1:0] pr;
        pr = {{EW{1'b0}}, a} * {{EW{1'b0}}, b};
        case (o)
            0: return a + b;
            1: return pr[EW-1:0];
            default: return a;
        endcase
    endfunction

    // runs one command, updates the model and checks timing, predicate and results
    task automatic run_op(input int o, input logic dn, input int vl_in,
                          input string req, input int intrude);
        int vl, k, cyc;
        vl = (vl_in > NE) ? NE : vl_in;
        k = 0;
        if (o <= 2) begin
            for (int i = 0; i < vl; i++) begin
                if (mask_m[i]) begin
                    k++;
                    vd_m[i] = model_res(o, va[i], vb[i]);
                end
            end
            if (!dn) k = vl;
        end else if (o == 3 || o == 4) begin
            k = vl;
            for (int i = 0; i < NE; i++)
                mask_m[i] = (i < vl) && ((o == 3) ? (va[i] != '0)
                                                  : ($signed(va[i]) >= $signed(vb[i])));
        end else if (o == 5) begin
            for (int i = 0; i < NE; i++) mask_m[i] = (i < vl) && !mask_m[i];
        end
        @(negedge clk);
        op = 3'(o); dense = dn; vlen = LW'(vl_in); start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (intrude != 0 && cyc == 3) begin
                start = 1'b1; op = 3'd5; vlen = LW'(NE);
            end
        end while (!done && cyc < 100);
        start = 1'b0;
        chk(req, "cycles start->done", 64'(cyc), 64'(k + 1));
        chk(req, "predicate", 64'(mask), 64'(mask_m));
        for (int i = 0; i < NE; i++)
            chk(req, $sformatf("element %0d", i), 64'(vd[i]), 64'(vd_m[i]));
        @(negedge clk);
        chk("R11", "done pulse dropped", 64'({done, busy}), 64'd0);
    endtask

    // op(3) dense(1) vlen(4) pattern(3)
    localparam int NT = 12;
    localparam logic [10:0] TBL [NT] = '{
        {3'd3, 1'b0, 4'd8,  3'd1},
        {3'd0, 1'b0, 4'd8,  3'd1},
        {3'd0, 1'b1, 4'd8,  3'd1},
        {3'd5, 1'b0, 4'd8,  3'd0},
        {3'd1, 1'b1, 4'd8,  3'd2},
        {3'd4, 1'b0, 4'd6,  3'd2},
        {3'd2, 1'b1, 4'd8,  3'd2},
        {3'd5, 1'b0, 4'd6,  3'd3},
        {3'd2, 1'b1, 4'd5,  3'd3},
        {3'd1, 1'b0, 4'd12, 3'd4},
        {3'd0, 1'b0, 4'd0,  3'd4},
        {3'd6, 1'b0, 4'd8,  3'd4}
    };
    localparam string TREQ [NT] = '{"R2", "R6", "R7", "R4", "R5", "R3",
                                    "R7", "R4", "R7", "R6", "R8", "R10"};

    initial begin
        mask_m = '0;
        set_pat(0);
        for (int i = 0; i < NE; i++) vd_m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy/done/wr_en after reset", 64'({busy, done, wr_en}), 64'd0);
        chk("R1", "predicate after reset", 64'(mask), 64'd0);
        clear_vd();

        for (int t = 0; t < NT; t++) begin
            set_pat(int'(TBL[t][2:0]));
            run_op(int'(TBL[t][10:8]), TBL[t][7], int'(TBL[t][6:3]), TREQ[t], 0);
        end
        run_op(7, 1'b1, 8, "R10", 0);

        // merge into element-wise signed maximum (R4)
        begin
            logic [EW-1:0] sa [NE];
            logic [EW-1:0] sb [NE];
            clear_vd();
            set_pat(5);
            for (int i = 0; i < NE; i++) begin sa[i] = va[i]; sb[i] = vb[i]; end
            run_op(4, 1'b0, 8, "R3", 0);
            run_op(2, 1'b0, 8, "R5", 0);
            run_op(5, 1'b0, 8, "R4", 0);
            for (int i = 0; i < NE; i++) va[i] = sb[i];
            run_op(2, 1'b1, 8, "R7", 0);
            for (int i = 0; i < NE; i++)
                chk("R4", $sformatf("max element %0d", i), 64'(vd[i]),
                    64'(($signed(sa[i]) >= $signed(sb[i])) ? sa[i] : sb[i]));
        end

        // all-zero predicate in sparse mode (R8)
        for (int i = 0; i < NE; i++) va[i] = '0;
        run_op(3, 1'b0, 8, "R2", 0);
        chk("R8", "predicate all clear", 64'(mask), 64'd0);
        run_op(0, 1'b1, 8, "R8", 0);

        // start pulse during a run is ignored (R9)
        set_pat(6);
        run_op(3, 1'b0, 8, "R2", 0);
        run_op(0, 1'b0, 8, "R9", 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule